// File: doc/BRIEF.md
# Triple-Copy Majority Readback Voter

This block rebuilds a stored image from three redundant copies held in three separate regions of an external memory. After a start pulse it walks the byte offsets of the image from zero upward. For each offset it fetches the byte from each of the three regions, one read at a time, through a single request/valid memory port. It then forms the bitwise majority of the three bytes and presents the result on a valid/ready output stream.

Whenever the three copies at an offset are not all identical, the block treats that offset as an anomaly, even if a majority value exists. It raises a sticky anomaly flag and advances a saturating anomaly counter. Both are cleared when the next run starts. A consumer reads the voted stream, marked by a last-byte indicator, and checks the flag and counter at the end of the run to decide whether the stored copies need repair.

Top module: `tmr_readback_voter`

## Requirements
- R1: After reset, busy, mem_req, out_valid, mismatch_flag and mismatch_count are all 0.
- R2: A start pulse while idle with a nonzero length latches the three base addresses and the length, clears mismatch_flag and mismatch_count, and raises busy. A start with length 0 is ignored: busy stays 0 and no read is issued. A start while busy is ignored, and so are later changes on the base and length inputs during a run.
- R3: For each offset, exactly three reads are issued, in the order copy 0, copy 1, copy 2. Each read is a one-cycle mem_req pulse. The next read is issued only after mem_rvalid has returned the previous one.
- R4: out_data is the bitwise majority of the three bytes returned for that offset. A bit is 1 when at least two of the copies have it at 1.
- R5: out_valid rises only after the third read of an offset has returned. While out_valid is 1 and out_ready is 0, out_valid and out_data hold. No mem_req is issued while out_valid is 1.
- R6: out_last is 1 together with out_valid on the final offset (length-1) and 0 on every other offset. After that byte is accepted, busy returns to 0.
- R7: Voted bytes appear in ascending offset order 0 to length-1. Each read address is the base of its copy plus the offset.
- R8: mismatch_count increases by one for each offset whose three copies are not all identical. The new value is visible in the cycle in which out_valid first presents that offset.
- R9: mismatch_count is CNT_W bits wide (default 16) and saturates at all-ones.
- R10: mismatch_flag becomes 1 with the first mismatching offset of a run and stays 1 until the next accepted start.
- R11: A read address that passes the top of the address space wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle and length is nonzero |
| base0 | input | ADDR_W | Base address of copy 0 |
| base1 | input | ADDR_W | Base address of copy 1 |
| base2 | input | ADDR_W | Base address of copy 2 |
| length | input | LEN_W | Image length in bytes |
| busy | output | 1 | A run is in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Read address, valid with mem_req |
| mem_rvalid | input | 1 | Read data return strobe |
| mem_rdata | input | DATA_W | Returned read data |
| out_valid | output | 1 | Voted byte available |
| out_ready | input | 1 | Consumer accepts the voted byte |
| out_data | output | DATA_W | Voted byte |
| out_last | output | 1 | Voted byte is the final offset |
| mismatch_flag | output | 1 | Sticky: some offset disagreed in this run |
| mismatch_count | output | CNT_W | Saturating count of disagreeing offsets |

## Verification
The assertions take for granted that the memory returns exactly one mem_rvalid for each mem_req, never while no read is outstanding and never in the same cycle as a new request. They also assume that out_ready may change freely. The bench memory model answers each request once, with a latency of one to three cycles, and only after the request has been seen. The consumer model drives out_ready with steady, alternating and mostly-low patterns, so stalls of several cycles occur while bytes are pending.

// File: rtl/tmr_vote_pkg.sv
`timescale 1ns/1ps
package tmr_vote_pkg;
   localparam int unsigned COPIES = 3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_AWAIT = 2'd2,
      ST_OFFER = 2'd3
   } fetch_state_t;
endpackage

// File: rtl/tmr_vote_bitwise.sv
`timescale 1ns/1ps
module tmr_vote_bitwise #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IMPL   = 0
) (
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic [DATA_W-1:0] in_c,
   output logic [DATA_W-1:0] voted,
   output logic              disagree
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (IMPL == 0) begin : g_sop
         assign voted[i] = (in_a[i] & in_b[i]) | (in_a[i] & in_c[i]) | (in_b[i] & in_c[i]);
      end else begin : g_mux
         assign voted[i] = (in_a[i] == in_b[i]) ? in_a[i] : in_c[i];
      end
   end

   assign disagree = (in_a != in_b) || (in_a != in_c);
endmodule

// File: rtl/tmr_mismatch_tally.sv
`timescale 1ns/1ps
module tmr_mismatch_tally #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             hit,
   output logic             flag,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         count <= '0;
      end else if (clear) begin
         flag  <= 1'b0;
         count <= '0;
      end else if (hit) begin
         flag <= 1'b1;
         if (count != CNT_MAX) count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/tmr_fetch_seq.sv
`timescale 1ns/1ps
module tmr_fetch_seq
   import tmr_vote_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base0,
   input  logic [ADDR_W-1:0] base1,
   input  logic [ADDR_W-1:0] base2,
   input  logic [LEN_W-1:0]  length,
   output logic              busy,
   output logic              run_clear,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] cap_first,
   output logic [DATA_W-1:0] cap_second,
   output logic              vote_load,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_last
);
   localparam int unsigned CP_W = $clog2(COPIES);
   localparam logic [CP_W-1:0] CP_LAST = CP_W'(COPIES - 1);

   fetch_state_t      state_q;
   logic [ADDR_W-1:0] base_q [COPIES];
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  off_q;
   logic [CP_W-1:0]   copy_q;
   logic [ADDR_W-1:0] base_sel;
   logic              accept;
   logic              final_off;

   assign accept    = start && (state_q == ST_IDLE) && (length != '0);
   assign final_off = (off_q == len_q - 1'b1);

   always_comb begin
      case (copy_q)
         CP_W'(0): base_sel = base_q[0];
         CP_W'(1): base_sel = base_q[1];
         default:  base_sel = base_q[2];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         len_q      <= '0;
         off_q      <= '0;
         copy_q     <= '0;
         cap_first  <= '0;
         cap_second <= '0;
         for (int k = 0; k < COPIES; k++) base_q[k] <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  base_q[0] <= base0;
                  base_q[1] <= base1;
                  base_q[2] <= base2;
                  len_q     <= length;
                  off_q     <= '0;
                  copy_q    <= '0;
                  state_q   <= ST_ISSUE;
               end
            end
            ST_ISSUE: state_q <= ST_AWAIT;
            ST_AWAIT: begin
               if (mem_rvalid) begin
                  if (copy_q == CP_LAST) begin
                     state_q <= ST_OFFER;
                  end else begin
                     if (copy_q == '0) cap_first <= mem_rdata;
                     else              cap_second <= mem_rdata;
                     copy_q  <= copy_q + 1'b1;
                     state_q <= ST_ISSUE;
                  end
               end
            end
            ST_OFFER: begin
               if (out_ready) begin
                  if (final_off) begin
                     state_q <= ST_IDLE;
                  end else begin
                     off_q   <= off_q + 1'b1;
                     copy_q  <= '0;
                     state_q <= ST_ISSUE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign run_clear = accept;
   assign mem_req   = (state_q == ST_ISSUE);
   assign mem_addr  = base_sel + ADDR_W'(off_q);
   assign vote_load = (state_q == ST_AWAIT) && mem_rvalid && (copy_q == CP_LAST);
   assign out_valid = (state_q == ST_OFFER);
   assign out_last  = out_valid && final_off;
endmodule

// File: rtl/tmr_readback_voter.sv
`timescale 1ns/1ps
module tmr_readback_voter #(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned VOTE_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base0,
   input  logic [ADDR_W-1:0] base1,
   input  logic [ADDR_W-1:0] base2,
   input  logic [LEN_W-1:0]  length,
   output logic              busy,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic              mismatch_flag,
   output logic [CNT_W-1:0]  mismatch_count
);
   if (LEN_W > ADDR_W) begin : g_bad_len
      $error("LEN_W must not exceed ADDR_W");
   end
   if (DATA_W < 1 || CNT_W < 1 || ADDR_W < 1 || LEN_W < 1) begin : g_bad_width
      $error("all widths must be at least 1");
   end
   if (VOTE_IMPL > 1) begin : g_bad_impl
      $error("VOTE_IMPL selects 0 (sum of products) or 1 (mux)");
   end

   logic              run_clear;
   logic              vote_load;
   logic [DATA_W-1:0] cap_first;
   logic [DATA_W-1:0] cap_second;
   logic [DATA_W-1:0] voted;
   logic              disagree;
   logic [DATA_W-1:0] out_data_q;

   tmr_fetch_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .base0      (base0),
      .base1      (base1),
      .base2      (base2),
      .length     (length),
      .busy       (busy),
      .run_clear  (run_clear),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .cap_first  (cap_first),
      .cap_second (cap_second),
      .vote_load  (vote_load),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_last   (out_last)
   );

   tmr_vote_bitwise #(
      .DATA_W (DATA_W),
      .IMPL   (VOTE_IMPL)
   ) u_vote (
      .in_a     (cap_first),
      .in_b     (cap_second),
      .in_c     (mem_rdata),
      .voted    (voted),
      .disagree (disagree)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         out_data_q <= '0;
      else if (vote_load) out_data_q <= voted;
   end
   assign out_data = out_data_q;

   tmr_mismatch_tally #(
      .CNT_W (CNT_W)
   ) u_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (run_clear),
      .hit   (vote_load && disagree),
      .flag  (mismatch_flag),
      .count (mismatch_count)
   );
endmodule

// File: rtl/tmr_voter_checks.sv
`timescale 1ns/1ps
module tmr_voter_checks #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mem_req,
   input logic              mem_rvalid,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              mismatch_flag,
   input logic [CNT_W-1:0]  mismatch_count
);
   logic pending;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pending <= 1'b0;
      else if (mem_req)    pending <= 1'b1;
      else if (mem_rvalid) pending <= 1'b0;
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !out_valid));
   // R3
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R3
   resp_matches_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |-> (pending && !mem_req));
   // R5
   no_req_while_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && out_valid));
   // R5
   hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   // R9
   count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (mismatch_count >= $past(mismatch_count)));
   // R10
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mismatch_flag) |=> mismatch_flag);
   // R8
   count_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mismatch_count != '0) |-> mismatch_flag);
endmodule

bind tmr_readback_voter tmr_voter_checks #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .busy           (busy),
   .mem_req        (mem_req),
   .mem_rvalid     (mem_rvalid),
   .out_valid      (out_valid),
   .out_ready      (out_ready),
   .out_data       (out_data),
   .mismatch_flag  (mismatch_flag),
   .mismatch_count (mismatch_count)
);

// File: tb/sim_tmr_readback_voter.sv
`timescale 1ns/1ps
module sim_tmr_readback_voter;
   localparam int AW = 12;
   localparam int DW = 8;
   localparam int LW = 8;
   localparam int CW = 4;
   localparam int CMAX = 15;
   localparam int NVEC = 12;
   // each entry: copy0, copy1, copy2, expected voted byte
   localparam logic [31:0] VEC [NVEC] = '{
      32'h5A5A5A5A, 32'h00FFFFFF, 32'hF00FFFFF, 32'h12123412,
      32'h817E8181, 32'hAA550000, 32'hC3C3C3C3, 32'h01020400,
      32'hFEFDFBFF, 32'h3C3C3C3C, 32'h77665577, 32'hE7E7E6E7
   };

   logic clk = 0, rst_n = 0, start = 0;
   logic [AW-1:0] base0 = '0, base1 = '0, base2 = '0;
   logic [LW-1:0] length = '0;
   logic busy, mem_req, mem_rvalid = 0, out_valid, out_ready = 1, out_last, mismatch_flag;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata = '0, out_data;
   logic [CW-1:0] mismatch_count;

   always #10 clk = ~clk;

   tmr_readback_voter #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .base0(base0), .base1(base1),
      .base2(base2), .length(length), .busy(busy), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last), .mismatch_flag(mismatch_flag), .mismatch_count(mismatch_count));

   logic [7:0] mem [4096];
   int checks = 0, fails = 0;
   int rb [3];
   int rlen = 0, exp_off = 0, exp_copy = 0, acc = 0, exp_mis = 0, reqs = 0;
   int ready_mode = 0, cyc = 0;
   logic stall_prev = 0;
   logic [7:0] stall_data;
   logic [7:0] exp_q [64];
   logic       mis_q [64];

   task automatic check(input logic ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [7:0] maj(input logic [7:0] a, b, c);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = (int'(a[i]) + int'(b[i]) + int'(c[i])) >= 2;
      return r;
   endfunction

   function automatic int addr_of(input int k, input int off);
      return (rb[k] + off) & 12'hFFF;
   endfunction

   // memory model: one response per request, latency 1..3 cycles
   initial begin
      forever begin
         @(negedge clk);
         mem_rvalid = 0;
         if (mem_req) begin
            int a;
            a = int'(mem_addr);
            reqs++;
            check(!out_valid, "R5 mem_req while out_valid", int'(out_valid), 0);
            check(a == addr_of(exp_copy, exp_off), "R3/R7/R11 read address", a,
                  addr_of(exp_copy, exp_off));
            exp_copy++;
            if (exp_copy == 3) begin exp_copy = 0; exp_off++; end
            for (int w = 0; w < 1 + (reqs % 3); w++) @(negedge clk);
            mem_rdata = mem[a];
            mem_rvalid = 1;
         end
      end
   end

   // consumer model
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (stall_prev)
            check(out_valid && out_data == stall_data, "R5 hold while stalled",
                  int'(out_data), int'(stall_data));
         case (ready_mode)
            0: out_ready = 1;
            1: out_ready = cyc[0];
            default: out_ready = (cyc % 4) == 0;
         endcase
         if (out_valid && !stall_prev && acc < 64) begin
            int nm;
            nm = exp_mis + (mis_q[acc] ? 1 : 0);
            check(out_data == exp_q[acc], "R4 voted byte", int'(out_data), int'(exp_q[acc]));
            check(int'(mismatch_count) == (nm > CMAX ? CMAX : nm), "R8/R9 mismatch count",
                  int'(mismatch_count), (nm > CMAX ? CMAX : nm));
            check(mismatch_flag == (nm != 0), "R10 sticky flag", int'(mismatch_flag),
                  int'(nm != 0));
            check(out_last == (acc == rlen - 1), "R6 last marker", int'(out_last),
                  int'(acc == rlen - 1));
            exp_mis = nm;
         end
         if (out_valid && out_ready) begin acc++; stall_prev = 0; end
         else if (out_valid) begin stall_prev = 1; stall_data = out_data; end
         else stall_prev = 0;
      end
   end

   task automatic run(input int b0, b1, b2, len, mode);
      rb[0] = b0; rb[1] = b1; rb[2] = b2;
      rlen = len; exp_off = 0; exp_copy = 0; acc = 0; exp_mis = 0;
      ready_mode = mode;
      for (int i = 0; i < len; i++) begin
         logic [7:0] x, y, z;
         x = mem[addr_of(0, i)]; y = mem[addr_of(1, i)]; z = mem[addr_of(2, i)];
         if (mode != 3) exp_q[i] = maj(x, y, z);
         mis_q[i] = (x != y) || (x != z);
      end
      if (mode == 3) ready_mode = 1;
      @(negedge clk);
      base0 = AW'(b0); base1 = AW'(b1); base2 = AW'(b2); length = LW'(len);
      start = 1;
      @(negedge clk);
      start = 0;
      check(busy, "R2 busy after start", int'(busy), 1);
      check(mismatch_count == 0 && !mismatch_flag, "R2 tally cleared at start",
            int'(mismatch_count), 0);
      while (acc < len) @(posedge clk);
      @(negedge clk);
      @(negedge clk);
      check(!busy, "R6 idle after last byte", int'(busy), 0);
      check(acc == len, "R7 byte count", acc, len);
      check(exp_off == len && exp_copy == 0, "R3 read count", exp_off, len);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R6 watchdog: run never finished actual=%0d expected=%0d", acc, rlen);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + 11);
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !mem_req && !out_valid, "R1 idle outputs", int'(busy), 0);
      check(!mismatch_flag && mismatch_count == 0, "R1 tally reset", int'(mismatch_count), 0);
      rst_n = 1;
      @(negedge clk);

      // R4 table walk with alternating ready
      for (int v = 0; v < NVEC; v++) begin
         mem[12'h100 + v] = VEC[v][31:24];
         mem[12'h400 + v] = VEC[v][23:16];
         mem[12'h900 + v] = VEC[v][15:8];
         exp_q[v] = VEC[v][7:0];
      end
      fork
         begin
            // R2: start and input changes during a run are ignored
            repeat (25) @(negedge clk);
            base0 = 12'hABC; base1 = 12'hABC; base2 = 12'hABC; length = 8'd1;
            start = 1;
            @(negedge clk);
            start = 0;
         end
      join_none
      run(12'h100, 12'h400, 12'h900, NVEC, 3);
      check(mismatch_count == 4'd9 && mismatch_flag, "R8 table mismatch total",
            int'(mismatch_count), 9);

      // R2 length zero ignored
      begin
         int r0;
         r0 = reqs;
         @(negedge clk);
         length = '0; start = 1;
         @(negedge clk);
         start = 0;
         repeat (4) @(negedge clk);
         check(!busy, "R2 zero length keeps idle", int'(busy), 0);
         check(reqs == r0, "R2 zero length issues no read", reqs, r0);
         check(mismatch_count == 4'd9, "R2 zero length keeps tally", int'(mismatch_count), 9);
      end

      // R9 saturation: every offset disagrees
      for (int i = 0; i < 20; i++) begin
         mem[12'h200 + i] = 8'(i * 5);
         mem[12'h500 + i] = 8'(i * 5) ^ 8'h01;
         mem[12'hA00 + i] = (i % 2 == 1) ? (8'(i * 5) ^ 8'h80) : 8'(i * 5);
      end
      run(12'h200, 12'h500, 12'hA00, 20, 0);
      check(mismatch_count == 4'd15, "R9 saturated count", int'(mismatch_count), 15);

      // R10 new run clears; identical copies under heavy stall
      for (int i = 0; i < 10; i++) begin
         mem[12'h300 + i] = 8'(i ^ 8'h6C);
         mem[12'h600 + i] = 8'(i ^ 8'h6C);
         mem[12'hB00 + i] = 8'(i ^ 8'h6C);
      end
      run(12'h300, 12'h600, 12'hB00, 10, 2);
      check(mismatch_count == 0 && !mismatch_flag, "R10 clean run leaves tally clear",
            int'(mismatch_count), 0);

      // R11 address wrap on copy 2
      for (int i = 0; i < 4; i++) begin
         mem[12'h040 + i] = 8'(8'h90 + i);
         mem[12'h080 + i] = 8'(8'h90 + i);
         mem[(12'hFFE + i) & 12'hFFF] = (i == 2) ? 8'h0F : 8'(8'h90 + i);
      end
      run(12'h040, 12'h080, 12'hFFE, 4, 1);
      check(mismatch_count == 4'd1 && mismatch_flag, "R11 wrap run one mismatch",
            int'(mismatch_count), 1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule